// File: doc/BRIEF.md
# Receive Alarm Change-of-State Interrupt Unit

This block sits behind a DS3 receive framer and turns its alarm indications into interrupts. Level alarms (loss of signal, AIS, idle, out-of-frame, AIC) and a far-end-receive-failure (FERF) state, derived here from the two X bits of each frame, raise an interrupt whenever they are declared and again whenever they are released. The P-bit and CP-bit parity error pulses raise an interrupt on every error.

Each source has an enable bit and a sticky status bit. A status bit is set only while its enable is set, and it clears itself when software reads the status register. The interrupt output is high while any enabled status bit is set. Software reaches three byte-wide registers: live alarm levels, enables and sticky status. After an interrupt it reads the live register to learn the present alarm state.

Top module: `rx_alarm_irq`

## Requirements
- R1: On a frame strobe while in frame (out-of-frame low), FERF is declared when both X bits are 0.
- R2: On a frame strobe while in frame, FERF is cleared when either X bit is 1. FERF keeps its value in cycles without a strobe and while out-of-frame is high.
- R3: Each level source (LOS, AIS, idle, out-of-frame, AIC, FERF) sets its status bit both when it goes from 0 to 1 and when it goes from 1 to 0.
- R4: The P-bit and CP-bit error inputs set their status bits on every single-cycle pulse.
- R5: The status register at address 0x13 and the enable register at 0x12 share one layout: bit 7 CP-bit error, 6 LOS, 5 AIS, 4 idle, 3 FERF, 2 AIC, 1 out-of-frame, 0 P-bit error. The enable register can be written and read back.
- R6: A read of address 0x13 (read strobe high) returns the latched status bits in that cycle and clears them on the following clock edge.
- R7: An event that arrives in the same cycle as a status read stays latched after the clear.
- R8: A status bit latches only while its enable bit is 1. All enables and status bits are 0 after reset.
- R9: The interrupt output equals the OR of all status bits ANDed with their enables. Clearing an enable masks the interrupt and leaves the latched bit in place.
- R10: The live register at address 0x10 shows AIS at bit 7, LOS at bit 6, idle at bit 5 and out-of-frame at bit 4. Bits 3 to 0 read 0.
- R11: Any address other than 0x10, 0x12 and 0x13 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_strobe_i | input | 1 | One cycle per received frame, X bits valid |
| xbits_i | input | 2 | X bit pair of the current frame |
| los_i | input | 1 | Loss of signal level |
| ais_i | input | 1 | AIS level |
| idle_i | input | 1 | Idle pattern level |
| oof_i | input | 1 | Out-of-frame level |
| aic_i | input | 1 | AIC level |
| pbit_err_i | input | 1 | P-bit parity error pulse |
| cpbit_err_i | input | 1 | CP-bit parity error pulse |
| reg_addr_i | input | 8 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from address |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Assertions check on every cycle how the FERF state follows the strobe, X bits and in-frame condition, that an enabled LOS change or P-bit pulse latches, and that a read clears the status only when no event arrives with it. They also check that such an event survives the clear and that nothing latches while every source is masked. Only the bench's scenarios show the exact register layouts, the latching of AIS, idle, AIC and out-of-frame on both edges, and the one-cycle lag of FERF events behind the strobe. The same holds for interrupt masking when an enable is removed, and for the long mixed sequences in which reads, enable writes and alarms overlap.

// File: rtl/rx_alarm_pkg.sv
package rx_alarm_pkg;
  localparam int STAT_W = 8;
  // status / enable bit positions
  localparam int B_PERR  = 0;
  localparam int B_OOF   = 1;
  localparam int B_AIC   = 2;
  localparam int B_FERF  = 3;
  localparam int B_IDLE  = 4;
  localparam int B_AIS   = 5;
  localparam int B_LOS   = 6;
  localparam int B_CPERR = 7;
  // live register positions
  localparam int L_OOF  = 4;
  localparam int L_IDLE = 5;
  localparam int L_LOS  = 6;
  localparam int L_AIS  = 7;
  localparam logic [STAT_W-1:0] LEVEL_MASK =
    STAT_W'((1 << B_OOF) | (1 << B_AIC) | (1 << B_FERF) |
            (1 << B_IDLE) | (1 << B_AIS) | (1 << B_LOS));
endpackage

// File: rtl/rx_ferf_detect.sv
module rx_ferf_detect (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_strobe_i,
  input  logic       in_frame_i,
  input  logic [1:0] xbits_i,
  output logic       ferf_o
);
  logic ferf_q;
  logic upd;

  assign upd = frame_strobe_i && in_frame_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  ferf_q <= 1'b0;
    else if (upd) ferf_q <= (xbits_i == 2'b00);
  end

  assign ferf_o = ferf_q;

  AST_FERF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && xbits_i == 2'b00) |=> ferf_o); // R1
  AST_FERF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && xbits_i != 2'b00) |=> !ferf_o); // R2
  AST_FERF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> $stable(ferf_o)); // R2
endmodule

// File: rtl/rx_cos_detect.sv
module rx_cos_detect #(
  parameter int           W          = 8,
  parameter logic [W-1:0] LEVEL_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] event_o
);
  for (genvar i = 0; i < W; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_level
      logic prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= src_i[i];
      end
      assign event_o[i] = src_i[i] ^ prev_q;
    end else begin : g_pulse
      assign event_o[i] = src_i[i];
    end
  end
endmodule

// File: rtl/rx_irq_status.sv
module rx_irq_status #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] event_i,
  input  logic         clr_i,
  input  logic         en_wr_i,
  input  logic [W-1:0] en_wdata_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] en_o,
  output logic         irq_o
);
  logic [W-1:0] status_q, en_q, set_v;

  assign set_v = event_i & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      en_q     <= '0;
    end else begin
      // set wins over read clear
      status_q <= (clr_i ? '0 : status_q) | set_v;
      if (en_wr_i) en_q <= en_wdata_i;
    end
  end

  assign status_o = status_q;
  assign en_o     = en_q;
  assign irq_o    = |(status_q & en_q);

  AST_EVENT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_v) |=> ((status_q & $past(set_v)) == $past(set_v))); // R7
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_v == '0) |=> (status_q == '0)); // R6
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q == '0 && en_q == '0) |=> (status_q == '0)); // R8
endmodule

// File: rtl/rx_alarm_irq.sv
module rx_alarm_irq
  import rx_alarm_pkg::*;
#(
  parameter int               ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ADDR_LIVE = 8'h10,
  parameter logic [ADDR_W-1:0] ADDR_EN   = 8'h12,
  parameter logic [ADDR_W-1:0] ADDR_STAT = 8'h13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_strobe_i,
  input  logic [1:0]        xbits_i,
  input  logic              los_i,
  input  logic              ais_i,
  input  logic              idle_i,
  input  logic              oof_i,
  input  logic              aic_i,
  input  logic              pbit_err_i,
  input  logic              cpbit_err_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [STAT_W-1:0] reg_wdata_i,
  output logic [STAT_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic              ferf;
  logic [STAT_W-1:0] src_v, event_v, status_v, en_v, live_v;
  logic              stat_clr, en_wr;

  rx_ferf_detect u_ferf (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .frame_strobe_i (frame_strobe_i),
    .in_frame_i     (!oof_i),
    .xbits_i        (xbits_i),
    .ferf_o         (ferf)
  );

  always_comb begin
    src_v          = '0;
    src_v[B_PERR]  = pbit_err_i;
    src_v[B_OOF]   = oof_i;
    src_v[B_AIC]   = aic_i;
    src_v[B_FERF]  = ferf;
    src_v[B_IDLE]  = idle_i;
    src_v[B_AIS]   = ais_i;
    src_v[B_LOS]   = los_i;
    src_v[B_CPERR] = cpbit_err_i;
  end

  rx_cos_detect #(.W(STAT_W), .LEVEL_MASK(LEVEL_MASK)) u_cos (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (src_v),
    .event_o (event_v)
  );

  assign stat_clr = reg_rd_i && (reg_addr_i == ADDR_STAT);
  assign en_wr    = reg_wr_i && (reg_addr_i == ADDR_EN);

  rx_irq_status #(.W(STAT_W)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .event_i    (event_v),
    .clr_i      (stat_clr),
    .en_wr_i    (en_wr),
    .en_wdata_i (reg_wdata_i),
    .status_o   (status_v),
    .en_o       (en_v),
    .irq_o      (irq_o)
  );

  always_comb begin
    live_v         = '0;
    live_v[L_AIS]  = ais_i;
    live_v[L_LOS]  = los_i;
    live_v[L_IDLE] = idle_i;
    live_v[L_OOF]  = oof_i;
  end

  always_comb begin
    if (reg_addr_i == ADDR_LIVE)      reg_rdata_o = live_v;
    else if (reg_addr_i == ADDR_EN)   reg_rdata_o = en_v;
    else if (reg_addr_i == ADDR_STAT) reg_rdata_o = status_v;
    else                              reg_rdata_o = '0;
  end

  AST_LOS_BOTH_EDGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_v[B_LOS] && los_i != $past(los_i)) |=> status_v[B_LOS]); // R3
  AST_PBIT_EACH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_v[B_PERR] && pbit_err_i) |=> status_v[B_PERR]); // R4
endmodule

// File: tb/rx_alarm_irq_test.sv
`timescale 1ns/1ps
module rx_alarm_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0;
  logic [1:0] xb = 2'b11;
  logic       los = 0, ais = 0, idle = 0, oof = 0, aic = 0, perr = 0, cperr = 0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic       wr = 0, rd = 0;
  logic [7:0] rdata;
  logic       irq;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  rx_alarm_irq uut (
    .clk_i(clk), .rst_ni(rst_n), .frame_strobe_i(strobe), .xbits_i(xb),
    .los_i(los), .ais_i(ais), .idle_i(idle), .oof_i(oof), .aic_i(aic),
    .pbit_err_i(perr), .cpbit_err_i(cperr), .reg_addr_i(addr),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // reference model built from the requirements
  logic [7:0] m_stat, m_en, m_prev;
  logic       m_ferf;
  always @(posedge clk or negedge rst_n) begin
    logic [7:0] lv, ev;
    if (!rst_n) begin
      m_stat <= 0; m_en <= 0; m_prev <= 0; m_ferf <= 0;
    end else begin
      lv = {1'b0, los, ais, idle, m_ferf, aic, oof, 1'b0};
      ev = ((lv ^ m_prev) & 8'h7E) | {cperr, 6'b0, perr};
      m_stat <= ((rd && addr == 8'h13) ? 8'h00 : m_stat) | (ev & m_en);
      m_prev <= lv;
      if (strobe && !oof) m_ferf <= (xb == 2'b00);
      if (wr && addr == 8'h12) m_en <= wdata;
    end
  end

  function automatic logic [7:0] exp_rdata(logic [7:0] a);
    case (a)
      8'h10:   return {ais, los, idle, oof, 4'b0};
      8'h12:   return m_en;
      8'h13:   return m_stat;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string addr_tag(logic [7:0] a);
    case (a)
      8'h10:   return "R10";
      8'h12:   return "R5";
      8'h13:   return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic read_stat(string tag, logic [7:0] exp);
    @(negedge clk); addr = 8'h13; rd = 1; #1;
    check(tag, rdata, exp);
    @(negedge clk); rd = 0; addr = 8'h00;
  endtask

  task automatic wr_en(logic [7:0] v);
    @(negedge clk); addr = 8'h12; wr = 1; wdata = v;
    @(negedge clk); wr = 0; addr = 8'h00;
  endtask

  task automatic ferf_frame(logic [1:0] x);
    @(negedge clk); strobe = 1; xb = x;
    @(negedge clk); strobe = 0; xb = 2'b11;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); addr = 8'h13; #1;
    check("R8 status after reset", rdata, 8'h00);
    check("R9 irq after reset", {7'b0, irq}, 8'h00);
    addr = 8'h12; #1;
    check("R8 enables after reset", rdata, 8'h00);

    // R8: disabled sources do not latch
    @(negedge clk); los = 1; perr = 1;
    @(negedge clk); los = 0; perr = 0;
    read_stat("R8 masked events", 8'h00);

    wr_en(8'hFF);
    @(negedge clk); addr = 8'h12; #1;
    check("R5 enable readback", rdata, 8'hFF);
    addr = 8'h11; #1;
    check("R11 unmapped read", rdata, 8'h00);

    // R3 / R6: LOS rise, clear on read, LOS fall
    @(negedge clk); los = 1;
    @(negedge clk); addr = 8'h13; rd = 1; #1;
    check("R3 los rise", rdata, 8'h40);
    check("R9 irq with los", {7'b0, irq}, 8'h01);
    @(negedge clk); rd = 0; #1;
    check("R6 cleared after read", rdata, 8'h00);
    @(negedge clk); los = 0;
    read_stat("R3 los fall", 8'h40);

    // R10 live register, R5 layout
    @(negedge clk); ais = 1; idle = 1;
    @(negedge clk); addr = 8'h10; #1;
    check("R10 live ais+idle", rdata, 8'hA0);
    read_stat("R5 ais idle positions", 8'h30);
    @(negedge clk); ais = 0; idle = 0; aic = 1;
    read_stat("R3 ais idle fall aic rise", 8'h34);
    @(negedge clk); aic = 0;
    read_stat("R3 aic fall", 8'h04);

    // R1: FERF declared
    ferf_frame(2'b00);
    read_stat("R1 ferf declared", 8'h08);
    // R2: no update while out of frame
    @(negedge clk); oof = 1;
    read_stat("R3 oof rise", 8'h02);
    @(negedge clk); addr = 8'h10; #1;
    check("R10 live oof", rdata, 8'h10);
    ferf_frame(2'b11);
    @(negedge clk);
    read_stat("R2 hold while oof", 8'h00);
    @(negedge clk); oof = 0;
    read_stat("R3 oof fall", 8'h02);
    ferf_frame(2'b01);
    read_stat("R2 ferf cleared", 8'h08);

    // R4: every error pulse
    @(negedge clk); perr = 1;
    @(negedge clk); perr = 0;
    read_stat("R4 pbit first", 8'h01);
    @(negedge clk); perr = 1;
    @(negedge clk); perr = 0; cperr = 1;
    @(negedge clk); cperr = 0;
    read_stat("R4 pbit second and cpbit", 8'h81);

    // R7: event coincident with read
    @(negedge clk); addr = 8'h13; rd = 1; perr = 1; #1;
    check("R7 read value before event", rdata, 8'h00);
    @(negedge clk); rd = 0; perr = 0; #1;
    check("R7 event kept after clear", rdata, 8'h01);

    // R9: masking
    wr_en(8'h01);
    #1 check("R9 irq enabled", {7'b0, irq}, 8'h01);
    wr_en(8'h00);
    #1 check("R9 irq masked", {7'b0, irq}, 8'h00);
    read_stat("R9 bit held while masked", 8'h01);

    // mixed random phase against model
    for (int i = 0; i < 4000; i++) begin
      int op;
      @(negedge clk);
      if ($urandom % 16 == 0) los = ~los;
      if ($urandom % 16 == 0) ais = ~ais;
      if ($urandom % 16 == 0) idle = ~idle;
      if ($urandom % 24 == 0) oof = ~oof;
      if ($urandom % 16 == 0) aic = ~aic;
      strobe = ($urandom % 6 == 0);
      xb = 2'($urandom);
      perr = ($urandom % 12 == 0);
      cperr = ($urandom % 12 == 0);
      wr = 0; rd = 0;
      op = int'($urandom % 16);
      if (op < 4) begin
        case (op)
          0: addr = 8'h10; 1: addr = 8'h12; 2: addr = 8'h13; default: addr = 8'h11;
        endcase
        rd = 1;
      end else if (op == 4) begin
        addr = 8'h12; wr = 1; wdata = 8'($urandom);
      end else begin
        addr = 8'h13;
      end
      #1;
      check(addr_tag(addr), rdata, exp_rdata(addr));
      check("R9 irq", {7'b0, irq}, {7'b0, |(m_stat & m_en)});
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule